// File: doc/BRIEF.md
# Transceiver Lane Data Conditioner

This block sits on one transceiver lane, between the parallel side of the serializer/deserializer and the coding logic. It reshapes the parallel word in each direction.

- **Transmit path:** the word can have its bit order mirrored and its polarity flipped before it goes to the serializer.
- **Receive path:** the word from the deserializer can have its polarity flipped, its bit order mirrored and its two symbols exchanged.

The word carries two symbols. A static mode input selects 10-bit symbols (20 active bits) or 8-bit symbols (16 active bits).

Every feature has a static enable, which is held steady by configuration. The runtime control inputs only act while their feature's enable is set.

- The transmit polarity control is synchronous to `clk`.
- The three receive controls may come from any clock domain. Each passes through a two-flop synchronizer, so any change lands on a word boundary.

Each path has one output register, giving a latency of one cycle from input word to output word.

Top module: `lane_cond_top`

## Requirements
- R1: While `rst_n` is low, `tx_dout` and `rx_dout` are all zeros.
- R2: Each path has a latency of exactly one clock. The word on an input at a rising edge appears, transformed, on the matching output after that edge.
- R3: The active width is 20 bits when `cfg_sym10`=1 and 16 bits (bits 15:0) when `cfg_sym10`=0. In 8-bit mode, input bits 19:16 are ignored and output bits 19:16 are zero, whatever the settings.
- R4: With `cfg_tx_bitrev_en`=1, transmit output bit i equals input bit N-1-i, where N is the active width. No runtime input affects this.
- R5: With `cfg_tx_polinv_en`=1 and `tx_polinv_ctl`=1 (sampled with the same word), every active transmit bit is inverted. Inversion and mirroring combine.
- R6: With `cfg_rx_polinv_en`=1 and the synchronized `rx_polinv_ctl`=1, every active receive bit is inverted.
- R7: With `cfg_rx_bitrev_en`=1 and the synchronized `rx_bitrev_ctl`=1, receive output bit i equals the (processed) input bit N-1-i.
- R8: With `cfg_rx_symswap_en`=1 and the synchronized `rx_symswap_ctl`=1, the symbols are exchanged. The symbol at bit 0 moves to bit S and the symbol at bit S moves to bit 0, where S is 10 or 8.
- R9: The receive operations run in the order inversion, mirroring, symbol exchange. With both mirroring and exchange active, each symbol ends up bit-mirrored in its own position.
- R10: When a feature's static enable is 0, its runtime control has no effect, and with no feature active the data passes unchanged.
- R11: Each receive control passes two flops before use. A level applied before rising edge e1 first affects the word sampled at edge e3 (the third edge).
- R12: Every receive output word is produced under a single control setting. It is never partly transformed, even when a control changes close to a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sym10 | input | 1 | Static: 1 = 10-bit symbols, 0 = 8-bit symbols |
| cfg_tx_bitrev_en | input | 1 | Static: mirror transmit bit order |
| cfg_tx_polinv_en | input | 1 | Static: allow transmit polarity control |
| cfg_rx_polinv_en | input | 1 | Static: allow receive polarity control |
| cfg_rx_bitrev_en | input | 1 | Static: allow receive bit-order control |
| cfg_rx_symswap_en | input | 1 | Static: allow receive symbol-exchange control |
| tx_polinv_ctl | input | 1 | Runtime transmit inversion, synchronous |
| tx_din | input | 20 | Transmit word from coding logic |
| tx_dout | output | 20 | Transmit word to serializer |
| rx_polinv_ctl | input | 1 | Runtime receive inversion, asynchronous |
| rx_bitrev_ctl | input | 1 | Runtime receive mirroring, asynchronous |
| rx_symswap_ctl | input | 1 | Runtime receive symbol exchange, asynchronous |
| rx_din | input | 20 | Receive word from deserializer |
| rx_dout | output | 20 | Receive word to coding logic |

## Verification
A data word is due on its output one cycle after it is sampled. A change on a receive control is due three edges after it is applied, and a transmit control takes effect with the word it accompanies. The bench drives on falling edges and reads each output at the next falling edge. After every change of configuration or control it waits three cycles before comparing data, except in the dedicated test that steps through the synchronizer delay word by word. Near control edges, the check only accepts a whole word that is either fully transformed or left untouched.

// File: rtl/lane_cond_pkg.sv
package lane_cond_pkg;
  localparam int LC_SYM_W     = 10;
  localparam int LC_NARROW_W  = 8;
  localparam int LC_NSYM      = 2;
  localparam int LC_DATA_W    = LC_SYM_W * LC_NSYM;
  localparam int LC_NCTL      = 3;
  localparam int LC_CTL_POL   = 0;
  localparam int LC_CTL_REV   = 1;
  localparam int LC_CTL_SWAP  = 2;
  localparam int LC_SYNC_STG  = 2;

  typedef logic [LC_DATA_W-1:0] lc_word_t;

  function automatic int lc_sym_w(input logic sym10);
    return sym10 ? LC_SYM_W : LC_NARROW_W;
  endfunction

  function automatic int lc_width(input logic sym10);
    return lc_sym_w(sym10) * LC_NSYM;
  endfunction

  // clear bits above the active width
  function automatic lc_word_t lc_keep(input lc_word_t w, input logic sym10);
    lc_word_t r;
    int n;
    n = lc_width(sym10);
    r = '0;
    for (int i = 0; i < LC_DATA_W; i++)
      if (i < n) r[i] = w[i];
    return r;
  endfunction

  function automatic lc_word_t lc_bitrev(input lc_word_t w, input logic sym10);
    lc_word_t r;
    int n;
    n = lc_width(sym10);
    r = '0;
    for (int i = 0; i < LC_DATA_W; i++)
      if (i < n) r[i] = w[n-1-i];
    return r;
  endfunction

  function automatic lc_word_t lc_polinv(input lc_word_t w, input logic sym10);
    return lc_keep(~w, sym10);
  endfunction

  function automatic lc_word_t lc_symswap(input lc_word_t w, input logic sym10);
    lc_word_t r;
    int sw;
    sw = lc_sym_w(sym10);
    r = '0;
    for (int k = 0; k < LC_NSYM; k++)
      for (int b = 0; b < LC_SYM_W; b++)
        if (b < sw) r[k*sw + b] = w[(LC_NSYM-1-k)*sw + b];
    return r;
  endfunction
endpackage

// File: rtl/lane_cond_sync.sv
module lane_cond_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= async_in;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/lane_cond_tx.sv
module lane_cond_tx
  import lane_cond_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sym10,
  input  logic     bitrev_en,
  input  logic     polinv_en,
  input  logic     polinv_ctl,
  input  lc_word_t din,
  output lc_word_t dout,
  output logic     pol_act
);
  lc_word_t w_keep, w_rev, w_pol;

  assign pol_act = polinv_en & polinv_ctl;

  always_comb begin
    w_keep = lc_keep(din, sym10);
    w_rev  = bitrev_en ? lc_bitrev(w_keep, sym10) : w_keep;
    w_pol  = pol_act ? lc_polinv(w_rev, sym10) : w_rev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else dout <= w_pol;
  end
endmodule

// File: rtl/lane_cond_rx.sv
module lane_cond_rx
  import lane_cond_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sym10,
  input  logic [LC_NCTL-1:0] en,
  input  logic [LC_NCTL-1:0] ctl_sync,
  input  lc_word_t           din,
  output lc_word_t           dout,
  output logic [LC_NCTL-1:0] act
);
  lc_word_t w_keep, w_pol, w_rev, w_swp;

  assign act = en & ctl_sync;

  always_comb begin
    w_keep = lc_keep(din, sym10);
    w_pol  = act[LC_CTL_POL]  ? lc_polinv(w_keep, sym10) : w_keep;
    w_rev  = act[LC_CTL_REV]  ? lc_bitrev(w_pol, sym10)  : w_pol;
    w_swp  = act[LC_CTL_SWAP] ? lc_symswap(w_rev, sym10) : w_rev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else dout <= w_swp;
  end
endmodule

// File: rtl/lane_cond_top.sv
module lane_cond_top
  import lane_cond_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_sym10,
  input  logic                 cfg_tx_bitrev_en,
  input  logic                 cfg_tx_polinv_en,
  input  logic                 cfg_rx_polinv_en,
  input  logic                 cfg_rx_bitrev_en,
  input  logic                 cfg_rx_symswap_en,
  input  logic                 tx_polinv_ctl,
  input  logic [LC_DATA_W-1:0] tx_din,
  output logic [LC_DATA_W-1:0] tx_dout,
  input  logic                 rx_polinv_ctl,
  input  logic                 rx_bitrev_ctl,
  input  logic                 rx_symswap_ctl,
  input  logic [LC_DATA_W-1:0] rx_din,
  output logic [LC_DATA_W-1:0] rx_dout
);
  logic [LC_NCTL-1:0] rx_ctl_raw;
  logic [LC_NCTL-1:0] rx_ctl_sync;
  logic [LC_NCTL-1:0] rx_en;
  logic [LC_NCTL-1:0] rx_act;
  logic               tx_pol_act;

  assign rx_ctl_raw = {rx_symswap_ctl, rx_bitrev_ctl, rx_polinv_ctl};
  assign rx_en      = {cfg_rx_symswap_en, cfg_rx_bitrev_en, cfg_rx_polinv_en};

  lane_cond_sync #(.W(LC_NCTL), .STAGES(LC_SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (rx_ctl_raw),
    .sync_out (rx_ctl_sync)
  );

  lane_cond_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym10      (cfg_sym10),
    .bitrev_en  (cfg_tx_bitrev_en),
    .polinv_en  (cfg_tx_polinv_en),
    .polinv_ctl (tx_polinv_ctl),
    .din        (tx_din),
    .dout       (tx_dout),
    .pol_act    (tx_pol_act)
  );

  lane_cond_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym10    (cfg_sym10),
    .en       (rx_en),
    .ctl_sync (rx_ctl_sync),
    .din      (rx_din),
    .dout     (rx_dout),
    .act      (rx_act)
  );
endmodule

// File: rtl/lane_cond_chk.sv
module lane_cond_chk
  import lane_cond_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_sym10,
  input logic                 cfg_tx_bitrev_en,
  input logic                 tx_pol_act,
  input logic [LC_DATA_W-1:0] tx_din,
  input logic [LC_DATA_W-1:0] tx_dout,
  input logic [LC_NCTL-1:0]   rx_act,
  input logic [LC_NCTL-1:0]   rx_ctl_raw,
  input logic [LC_NCTL-1:0]   rx_ctl_sync,
  input logic [LC_DATA_W-1:0] rx_din,
  input logic [LC_DATA_W-1:0] rx_dout
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R3
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && $past(!cfg_sym10)) |-> (tx_dout[19:16] == 4'h0 && rx_dout[19:16] == 4'h0));

  // R10
  tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && $past(cfg_sym10 && !cfg_tx_bitrev_en && !tx_pol_act)) |-> tx_dout == $past(tx_din));

  // R10
  rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && $past(cfg_sym10 && rx_act == '0)) |-> rx_dout == $past(rx_din));

  // R4
  tx_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && $past(cfg_sym10 && !tx_pol_act)) |-> $countones(tx_dout) == $countones($past(tx_din)));

  // R5
  tx_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && $past(cfg_sym10 && !cfg_tx_bitrev_en && tx_pol_act)) |-> tx_dout == ~$past(tx_din));

  // R11
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> rx_ctl_sync == $past(rx_ctl_raw, 2));
endmodule

bind lane_cond_top lane_cond_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_sym10   (cfg_sym10),
  .cfg_tx_bitrev_en (cfg_tx_bitrev_en),
  .tx_pol_act  (tx_pol_act),
  .tx_din      (tx_din),
  .tx_dout     (tx_dout),
  .rx_act      (rx_act),
  .rx_ctl_raw  (rx_ctl_raw),
  .rx_ctl_sync (rx_ctl_sync),
  .rx_din      (rx_din),
  .rx_dout     (rx_dout)
);

// File: tb/sim_lane_cond_top.sv
`timescale 1ns/1ps
module sim_lane_cond_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sym10 = 1'b1, cfg_tx_bitrev_en = 1'b0, cfg_tx_polinv_en = 1'b0;
  logic cfg_rx_polinv_en = 1'b0, cfg_rx_bitrev_en = 1'b0, cfg_rx_symswap_en = 1'b0;
  logic tx_polinv_ctl = 1'b0, rx_polinv_ctl = 1'b0, rx_bitrev_ctl = 1'b0, rx_symswap_ctl = 1'b0;
  logic [19:0] tx_din = '0, rx_din = '0;
  logic [19:0] tx_dout, rx_dout;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  lane_cond_top u0 (.*);

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic longint mirror(input longint v, input int n);
    longint r = 0;
    for (int i = 0; i < n; i++) r = r * 2 + ((v >> i) & 1);
    return r;
  endfunction

  function automatic longint exchange(input longint v, input int s);
    longint m = longint'(1) << s;
    return (v % m) * m + (v / m) % m;
  endfunction

  function automatic logic [19:0] model(input logic [19:0] w, input bit sym, input bit pol,
                                        input bit rev, input bit swp);
    int n = sym ? 20 : 16;
    longint full = (longint'(1) << n) - 1;
    longint v = longint'(w) & full;
    if (pol) v = full - v;
    if (rev) v = mirror(v, n);
    if (swp) v = exchange(v, n / 2);
    return v[19:0];
  endfunction

  function automatic logic [19:0] pattern(input int p);
    case (p)
      0: return 20'h00001;
      1: return 20'hF8001;
      2: return 20'h3A5C7;
      3: return 20'hC03FF;
      default: return 20'h5A6B9;
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [19:0] prev_rx;
    tx_din = 20'hABCDE; rx_din = 20'h12345; tx_polinv_ctl = 1'b1; cfg_tx_polinv_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx", tx_dout, 20'h0);
    chk("R1 rx", rx_dout, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every mode, enable and control combination
    for (int m = 0; m < 64; m++) begin
      for (int c = 0; c < 16; c++) begin
        bit sym = m[5];
        bit tpe, tre, rpe, rre, rse;
        bit tp, rp, rr, rs;
        string ttag, rtag;
        {tre, tpe, rpe, rre, rse} = m[4:0];
        {tp, rp, rr, rs} = c[3:0];
        cfg_sym10 = sym; cfg_tx_bitrev_en = tre; cfg_tx_polinv_en = tpe;
        cfg_rx_polinv_en = rpe; cfg_rx_bitrev_en = rre; cfg_rx_symswap_en = rse;
        tx_polinv_ctl = tp; rx_polinv_ctl = rp; rx_bitrev_ctl = rr; rx_symswap_ctl = rs;
        repeat (3) @(negedge clk);
        ttag = !sym ? "R3 tx" : (tpe && tp) ? "R5 tx" : tre ? "R4 tx" : "R10 tx";
        rtag = !sym ? "R3 rx" : (rre && rr && rse && rs) ? "R9 rx" : (rse && rs) ? "R8 rx" :
               (rre && rr) ? "R7 rx" : (rpe && rp) ? "R6 rx" : "R10 rx";
        for (int p = 0; p < 5; p++) begin
          tx_din = pattern(p);
          rx_din = pattern(4 - p) ^ 20'h0F0F0;
          @(negedge clk);
          // R2: result is due one cycle after the word is sampled
          chk(ttag, tx_dout, model(pattern(p), sym, tpe && tp, tre, 1'b0));
          chk(rtag, rx_dout, model(pattern(4 - p) ^ 20'h0F0F0, sym, rpe && rp, rre && rr, rse && rs));
        end
      end
    end

    // R2: back-to-back distinct words, pass-through
    cfg_sym10 = 1'b1; {cfg_tx_bitrev_en, cfg_tx_polinv_en, cfg_rx_polinv_en, cfg_rx_bitrev_en, cfg_rx_symswap_en} = '0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      tx_din = 20'h11111 * k[3:0]; rx_din = ~(20'h11111 * k[3:0]);
      @(negedge clk);
      chk("R2 tx", tx_dout, 20'h11111 * k[3:0]);
      chk("R2 rx", rx_dout, ~(20'h11111 * k[3:0]));
    end

    // R11: synchronizer delay, word by word
    cfg_rx_polinv_en = 1'b1; rx_polinv_ctl = 1'b0; rx_bitrev_ctl = 1'b0; rx_symswap_ctl = 1'b0;
    repeat (3) @(negedge clk);
    rx_polinv_ctl = 1'b1; rx_din = 20'h0000F;
    @(negedge clk);
    chk("R11 e1", rx_dout, 20'h0000F);
    rx_din = 20'h000F0;
    @(negedge clk);
    chk("R11 e2", rx_dout, 20'h000F0);
    rx_din = 20'h00F00;
    @(negedge clk);
    chk("R11 e3", rx_dout, ~20'h00F00);

    // R12: control toggled just before rising edges, every word whole
    prev_rx = 20'h3C3C3;
    rx_din = prev_rx;
    for (int k = 0; k < 24; k++) begin
      #7 rx_polinv_ctl = ~rx_polinv_ctl;
      @(negedge clk);
      checks++;
      if (rx_dout !== prev_rx && rx_dout !== ~prev_rx) begin
        failures++;
        $display("FAIL R12 act=%h exp=%h or %h", rx_dout, prev_rx, ~prev_rx);
      end
      prev_rx = prev_rx + 20'h1357B;
      rx_din = prev_rx;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule